// File: doc/BRIEF.md
# Two-Handed Clock Page Reclaimer

This engine gives physical page frames back to a free list by sweeping two pointers across the frames in index order. The leading pointer (front hand) clears each frame's referenced flag as it passes. The trailing pointer (back hand) follows a programmable number of frames behind it. When the back hand reaches a mapped frame whose referenced flag is still clear, that frame is reclaimed. Before a modified (dirty) frame is reclaimed, the engine raises a write-back request and waits for the acknowledge.

The engine keeps its own count of free frames. It raises the count for every reclaimed frame and lowers it for every frame taken from the free list. The sweep runs only while this count is below a programmable target, and it halts as soon as the target is met.

Frame accesses feed the per-frame state. An access marks a frame as mapped and referenced, and a write access also marks it dirty. A revolution counter counts the back hand's wraps. A low-memory alarm fires when a wrap finds the free count still below a programmable floor.

Top module: `twohand_reclaimer`

## Requirements
- R1: After reset the free count, the revolution count, the alarm, the free pulse and the write-back request are all 0. The back hand is at frame 0, and nothing is sweeping while the target is 0.
- R2: The hands advance only while the free count is below `target_i`. Once the count equals the target, `sweeping_o` falls and both hands hold.
- R3: The front hand is the back hand plus `gap_i`, modulo the frame count. Each sweep step clears the referenced flag of the frame under the front hand and moves both hands forward by one frame.
- R4: A mapped, clean frame whose referenced flag is 0 under the back hand is reclaimed. The engine drives a one-cycle `free_valid_o` with the frame number on `free_frame_o`, raises the free count by 1, and unmaps the frame.
- R5: A frame with its referenced flag set, or a frame that is not mapped, is passed over by the back hand without being freed.
- R6: A dirty frame selected for reclaim raises `wb_req_o` with its number on `wb_frame_o`. The hands and the free count hold until `wb_ack_i`. In the acknowledge cycle the frame is freed and its dirty flag is cleared.
- R7: An access (`acc_valid_i`) sets the referenced and mapped flags of `acc_frame_i`, and sets its dirty flag when `acc_write_i` is 1. An access takes priority over a clear in the same cycle.
- R8: Each `take_i` pulse lowers the free count by 1. The count saturates at 0.
- R9: The revolution count rises by 1, one cycle after the back hand steps from the last frame to frame 0.
- R10: The alarm is set on the same edge as a revolution increment when the free count is below `floor_i`. It clears once the free count is at or above `floor_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | A frame access happens this cycle |
| acc_frame_i | input | FW | Frame number of the access |
| acc_write_i | input | 1 | The access is a write (marks the frame dirty) |
| take_i | input | 1 | One frame was taken from the free list |
| target_i | input | CW | Free-count target that stops the sweep |
| floor_i | input | CW | Free-count floor for the low-memory alarm |
| gap_i | input | FW | Distance from the back hand to the front hand |
| wb_ack_i | input | 1 | Write-back of the requested frame is complete |
| free_valid_o | output | 1 | One-cycle pulse: a frame was reclaimed |
| free_frame_o | output | FW | Number of the reclaimed frame |
| wb_req_o | output | 1 | Write-back request, held until acknowledged |
| wb_frame_o | output | FW | Frame to write back |
| free_count_o | output | CW | Current free-frame count |
| back_hand_o | output | FW | Back hand position |
| front_hand_o | output | FW | Front hand position |
| rev_count_o | output | REV_W | Completed revolutions of the back hand |
| sweeping_o | output | 1 | The engine is sweeping or waiting on a write-back |
| swap_alarm_o | output | 1 | Low-memory alarm |

## Verification
The bench targets the hand-off between the two hands. A frame must keep its referenced flag until the front hand reaches it, so a design that tested the flag under the wrong hand would free frames 0 and 1 at once instead of 2, 3 and 4. During a write-back stall the bench watches for hands or the count that keep moving, and for a frame that is freed before the acknowledge. It also checks that the sweep halts exactly at the target. A design that compared with the wrong inequality would free one frame too many. The alarm test places a revolution while the count is below the floor and then lifts the count above it. An alarm that never rose, rose at the wrong revolution, or stayed latched would each be reported.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;
    typedef enum logic {
        ST_WALK = 1'b0,
        ST_WAIT = 1'b1
    } walk_st_e;
endpackage

// File: rtl/reclaim_frame_store.sv
module reclaim_frame_store #(
    parameter int NFRAMES = 16,
    parameter int FW      = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid_i,
    input  logic [FW-1:0]      acc_frame_i,
    input  logic               acc_write_i,
    input  logic               clr_en_i,
    input  logic [FW-1:0]      clr_frame_i,
    input  logic               rcl_en_i,
    input  logic [FW-1:0]      rcl_frame_i,
    output logic [NFRAMES-1:0] refb_o,
    output logic [NFRAMES-1:0] dirty_o,
    output logic [NFRAMES-1:0] used_o
);
    typedef struct packed {
        logic [NFRAMES-1:0] refb;
        logic [NFRAMES-1:0] dirty;
        logic [NFRAMES-1:0] used;
    } bits_t;

    bits_t bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        for (int i = 0; i < NFRAMES; i++) begin
            if (clr_en_i && clr_frame_i == FW'(i)) begin
                bits_d.refb[i] = 1'b0;
            end
            if (rcl_en_i && rcl_frame_i == FW'(i)) begin
                bits_d.refb[i]  = 1'b0;
                bits_d.dirty[i] = 1'b0;
                bits_d.used[i]  = 1'b0;
            end
            // an access lands last, so it wins over a clear (R7)
            if (acc_valid_i && acc_frame_i == FW'(i)) begin
                bits_d.refb[i] = 1'b1;
                bits_d.used[i] = 1'b1;
                if (acc_write_i) begin
                    bits_d.dirty[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign refb_o  = bits_q.refb;
    assign dirty_o = bits_q.dirty;
    assign used_o  = bits_q.used;

    assert_access_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> (bits_q.refb[$past(acc_frame_i)] && bits_q.used[$past(acc_frame_i)]));

    assert_reclaim_unmaps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rcl_en_i && !(acc_valid_i && acc_frame_i == rcl_frame_i))
            |=> (!bits_q.used[$past(rcl_frame_i)] && !bits_q.dirty[$past(rcl_frame_i)]));
endmodule

// File: rtl/reclaim_hand_ctrl.sv
module reclaim_hand_ctrl
    import reclaim_pkg::*;
#(
    parameter int NFRAMES = 16,
    parameter int FW      = $clog2(NFRAMES),
    parameter int CW      = $clog2(NFRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NFRAMES-1:0] refb_i,
    input  logic [NFRAMES-1:0] dirty_i,
    input  logic [NFRAMES-1:0] used_i,
    input  logic               acc_valid_i,
    input  logic [FW-1:0]      acc_frame_i,
    input  logic               take_i,
    input  logic [CW-1:0]      target_i,
    input  logic [FW-1:0]      gap_i,
    input  logic               wb_ack_i,
    output logic               clr_en_o,
    output logic [FW-1:0]      clr_frame_o,
    output logic               rcl_en_o,
    output logic [FW-1:0]      rcl_frame_o,
    output logic               free_valid_o,
    output logic [FW-1:0]      free_frame_o,
    output logic               wb_req_o,
    output logic [FW-1:0]      wb_frame_o,
    output logic [CW-1:0]      count_o,
    output logic [FW-1:0]      back_o,
    output logic [FW-1:0]      front_o,
    output logic               sweeping_o,
    output logic               wrap_o
);
    localparam bit IS_POW2 = (NFRAMES & (NFRAMES - 1)) == 0;
    localparam logic [FW-1:0] LAST = FW'(NFRAMES - 1);

    typedef struct packed {
        walk_st_e      st;
        logic [FW-1:0] back;
        logic [CW-1:0] count;
        logic          free_v;
        logic [FW-1:0] free_f;
        logic          wb_req;
        logic [FW-1:0] wb_f;
        logic          wrap;
    } hand_t;

    hand_t s_d, s_q;
    logic [FW-1:0] front;
    logic          step, inc, back_hit;
    logic [CW:0]   cnt_w;

    generate
        if (IS_POW2) begin : g_front_p2
            assign front = s_q.back + gap_i;
        end else begin : g_front_mod
            logic [FW:0] sum;
            assign sum   = {1'b0, s_q.back} + {1'b0, gap_i};
            assign front = (sum >= (FW+1)'(NFRAMES)) ? FW'(sum - (FW+1)'(NFRAMES))
                                                     : sum[FW-1:0];
        end
    endgenerate

    assign back_hit = acc_valid_i && (acc_frame_i == s_q.back);

    always_comb begin
        s_d         = s_q;
        s_d.free_v  = 1'b0;
        s_d.wrap    = 1'b0;
        clr_en_o    = 1'b0;
        clr_frame_o = front;
        rcl_en_o    = 1'b0;
        rcl_frame_o = s_q.back;
        step        = 1'b0;
        inc         = 1'b0;
        case (s_q.st)
            ST_WALK: begin
                if (s_q.count < target_i) begin
                    clr_en_o = 1'b1;
                    if (used_i[s_q.back] && !refb_i[s_q.back] && !back_hit) begin
                        if (dirty_i[s_q.back]) begin
                            s_d.st     = ST_WAIT;
                            s_d.wb_req = 1'b1;
                            s_d.wb_f   = s_q.back;
                        end else begin
                            rcl_en_o   = 1'b1;
                            inc        = 1'b1;
                            s_d.free_v = 1'b1;
                            s_d.free_f = s_q.back;
                            step       = 1'b1;
                        end
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (wb_ack_i) begin
                    s_d.st     = ST_WALK;
                    s_d.wb_req = 1'b0;
                    rcl_en_o   = 1'b1;
                    inc        = 1'b1;
                    s_d.free_v = 1'b1;
                    s_d.free_f = s_q.wb_f;
                    step       = 1'b1;
                end
            end
            default: s_d.st = ST_WALK;
        endcase

        if (step) begin
            s_d.wrap = (s_q.back == LAST);
            s_d.back = (s_q.back == LAST) ? '0 : s_q.back + 1'b1;
        end

        cnt_w = {1'b0, s_q.count} + {{CW{1'b0}}, inc};
        if (take_i && cnt_w != '0) begin
            cnt_w = cnt_w - 1'b1;
        end
        if (cnt_w > (CW+1)'(NFRAMES)) begin
            cnt_w = (CW+1)'(NFRAMES);
        end
        s_d.count = cnt_w[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_WALK, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign free_valid_o = s_q.free_v;
    assign free_frame_o = s_q.free_f;
    assign wb_req_o     = s_q.wb_req;
    assign wb_frame_o   = s_q.wb_f;
    assign count_o      = s_q.count;
    assign back_o       = s_q.back;
    assign front_o      = front;
    assign sweeping_o   = (s_q.st == ST_WAIT) || (s_q.count < target_i);
    assign wrap_o       = s_q.wrap;

    assert_halt_at_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WALK && s_q.count >= target_i) |=> $stable(s_q.back));

    assert_stall_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && !wb_ack_i) |=> ($stable(s_q.back) && wb_req_o));

    assert_wb_frame_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> dirty_i[wb_frame_o]);

    assert_free_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && wb_ack_i) |=> (free_valid_o && !wb_req_o));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(NFRAMES));
endmodule

// File: rtl/reclaim_rev_alarm.sv
module reclaim_rev_alarm #(
    parameter int CW    = 5,
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic [CW-1:0]    count_i,
    input  logic [CW-1:0]    floor_i,
    output logic [REV_W-1:0] rev_o,
    output logic             alarm_o
);
    typedef struct packed {
        logic [REV_W-1:0] rev;
        logic             alarm;
    } ra_t;

    ra_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wrap_i) begin
            r_d.rev = r_q.rev + 1'b1;
        end
        if (wrap_i && count_i < floor_i) begin
            r_d.alarm = 1'b1;
        end else if (count_i >= floor_i) begin
            r_d.alarm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rev_o   = r_q.rev;
    assign alarm_o = r_q.alarm;

    assert_rev_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (r_q.rev == REV_W'($past(r_q.rev) + 1'b1)));

    assert_alarm_on_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.alarm) |-> $past(wrap_i));

    assert_alarm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i && count_i >= floor_i) |=> !r_q.alarm);
endmodule

// File: rtl/twohand_reclaimer.sv
module twohand_reclaimer #(
    parameter int  NFRAMES = 16,
    parameter int  REV_W   = 16,
    localparam int FW      = $clog2(NFRAMES),
    localparam int CW      = $clog2(NFRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid_i,
    input  logic [FW-1:0]    acc_frame_i,
    input  logic             acc_write_i,
    input  logic             take_i,
    input  logic [CW-1:0]    target_i,
    input  logic [CW-1:0]    floor_i,
    input  logic [FW-1:0]    gap_i,
    input  logic             wb_ack_i,
    output logic             free_valid_o,
    output logic [FW-1:0]    free_frame_o,
    output logic             wb_req_o,
    output logic [FW-1:0]    wb_frame_o,
    output logic [CW-1:0]    free_count_o,
    output logic [FW-1:0]    back_hand_o,
    output logic [FW-1:0]    front_hand_o,
    output logic [REV_W-1:0] rev_count_o,
    output logic             sweeping_o,
    output logic             swap_alarm_o
);
    logic [NFRAMES-1:0] refb, dirty, used;
    logic               clr_en, rcl_en, wrap;
    logic [FW-1:0]      clr_frame, rcl_frame;
    logic [CW-1:0]      count;

    reclaim_frame_store #(.NFRAMES(NFRAMES), .FW(FW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid_i),
        .acc_frame_i (acc_frame_i),
        .acc_write_i (acc_write_i),
        .clr_en_i    (clr_en),
        .clr_frame_i (clr_frame),
        .rcl_en_i    (rcl_en),
        .rcl_frame_i (rcl_frame),
        .refb_o      (refb),
        .dirty_o     (dirty),
        .used_o      (used)
    );

    reclaim_hand_ctrl #(.NFRAMES(NFRAMES), .FW(FW), .CW(CW)) u_hands (
        .clk          (clk),
        .rst_n        (rst_n),
        .refb_i       (refb),
        .dirty_i      (dirty),
        .used_i       (used),
        .acc_valid_i  (acc_valid_i),
        .acc_frame_i  (acc_frame_i),
        .take_i       (take_i),
        .target_i     (target_i),
        .gap_i        (gap_i),
        .wb_ack_i     (wb_ack_i),
        .clr_en_o     (clr_en),
        .clr_frame_o  (clr_frame),
        .rcl_en_o     (rcl_en),
        .rcl_frame_o  (rcl_frame),
        .free_valid_o (free_valid_o),
        .free_frame_o (free_frame_o),
        .wb_req_o     (wb_req_o),
        .wb_frame_o   (wb_frame_o),
        .count_o      (count),
        .back_o       (back_hand_o),
        .front_o      (front_hand_o),
        .sweeping_o   (sweeping_o),
        .wrap_o       (wrap)
    );

    reclaim_rev_alarm #(.CW(CW), .REV_W(REV_W)) u_rev (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap),
        .count_i (count),
        .floor_i (floor_i),
        .rev_o   (rev_count_o),
        .alarm_o (swap_alarm_o)
    );

    assign free_count_o = count;
endmodule

// File: tb/twohand_reclaimer_test.sv
`timescale 1ns/1ps
module twohand_reclaimer_test;
    localparam int N  = 8;
    localparam int FW = 3;
    localparam int CW = 4;
    localparam int RW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, take = 1'b0, wb_ack = 1'b0;
    logic [FW-1:0] acc_frame = '0, gap = 3'd2;
    logic [CW-1:0] target = '0, floor_v = '0;
    logic free_valid, wb_req, sweeping, alarm;
    logic [FW-1:0] free_frame, wb_frame, back, front;
    logic [CW-1:0] count;
    logic [RW-1:0] rev;

    int n_checks = 0, n_fail = 0, n_freed = 0, last_freed = -1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twohand_reclaimer #(.NFRAMES(N), .REV_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_frame_i(acc_frame),
        .acc_write_i(acc_write), .take_i(take), .target_i(target), .floor_i(floor_v),
        .gap_i(gap), .wb_ack_i(wb_ack), .free_valid_o(free_valid), .free_frame_o(free_frame),
        .wb_req_o(wb_req), .wb_frame_o(wb_frame), .free_count_o(count),
        .back_hand_o(back), .front_hand_o(front), .rev_count_o(rev),
        .sweeping_o(sweeping), .swap_alarm_o(alarm)
    );

    always @(negedge clk) begin
        if (free_valid) begin
            n_freed++;
            last_freed = int'(free_frame);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic access(input int f, input bit wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_frame = FW'(f); acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic take_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); take = 1'b1;
            @(negedge clk); take = 1'b0;
        end
    endtask

    // runs until the engine goes idle, acknowledging write-backs after a stall
    task automatic run_idle(input int exp_wb);
        int seen_wb = -1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (wb_req) begin
                int b0 = int'(back);
                int c0 = int'(count);
                seen_wb = int'(wb_frame);
                repeat (4) @(negedge clk);
                chk("R6 hand held during write-back", int'(back), b0);
                chk("R6 count held during write-back", int'(count), c0);
                chk("R6 request held", int'(wb_req), 1);
                wb_ack = 1'b1;
                @(negedge clk);
                wb_ack = 1'b0;
            end else if (!sweeping) begin
                break;
            end
        end
        @(negedge clk);
        chk("R6 write-back frame", seen_wb, exp_wb);
    endtask

    // vector table: takes, target, expected count/back/front/rev/freed/last/wb
    localparam int NV = 4;
    localparam int V_TAKE [NV] = '{0, 3, 0, 4};
    localparam int V_TGT  [NV] = '{3, 2, 4, 1};
    localparam int V_CNT  [NV] = '{3, 2, 4, 1};
    localparam int V_BACK [NV] = '{5, 7, 1, 2};
    localparam int V_REV  [NV] = '{0, 0, 1, 1};
    localparam int V_NFR  [NV] = '{3, 2, 2, 1};
    localparam int V_LAST [NV] = '{4, 6, 0, 1};
    localparam int V_WB   [NV] = '{-1, 5, -1, -1};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 free count", int'(count), 0);
        chk("R1 revolutions", int'(rev), 0);
        chk("R1 alarm", int'(alarm), 0);
        chk("R1 free pulse", int'(free_valid), 0);
        chk("R1 write-back", int'(wb_req), 0);
        chk("R1 back hand", int'(back), 0);
        chk("R1 idle", int'(sweeping), 0);
        chk("R3 front at gap", int'(front), 2);

        // R7: map all frames referenced, frame 5 written
        for (int f = 0; f < N; f++) access(f, f == 5);

        for (int v = 0; v < NV; v++) begin
            target = '0;
            take_n(V_TAKE[v]);
            n_freed = 0;
            @(negedge clk);
            target = CW'(V_TGT[v]);
            run_idle(V_WB[v]);
            chk($sformatf("R2 count v%0d", v), int'(count), V_CNT[v]);
            chk($sformatf("R3 back hand v%0d", v), int'(back), V_BACK[v]);
            chk($sformatf("R3 front hand v%0d", v), int'(front), (V_BACK[v] + 2) % N);
            chk($sformatf("R9 revolutions v%0d", v), int'(rev), V_REV[v]);
            chk($sformatf("R4 R5 R7 frames freed v%0d", v), n_freed, V_NFR[v]);
            chk($sformatf("R4 last freed v%0d", v), last_freed, V_LAST[v]);
            chk($sformatf("R2 halted v%0d", v), int'(sweeping), 0);
        end

        // R10 alarm: count below floor at a wrap, then lifted above it
        target = '0;
        take_n(1);
        access(3, 1'b0);
        access(6, 1'b0);
        floor_v = 4'd2;
        @(negedge clk);
        target = 4'd3;
        for (int k = 0; k < 100 && !alarm; k++) @(negedge clk);
        chk("R10 alarm raised", int'(alarm), 1);
        chk("R9 revolution at alarm", int'(rev), 2);
        chk("R10 count at alarm", int'(count), 1);
        for (int k = 0; k < 100 && count != 4'd2; k++) @(negedge clk);
        target = 4'd2;
        @(negedge clk);
        chk("R10 alarm cleared", int'(alarm), 0);
        chk("R4 last freed frame", last_freed, 3);
        run_idle(-1);
        chk("R2 halted at target", int'(count), 2);

        // R8 saturation at zero
        target = '0;
        take_n(3);
        @(negedge clk);
        chk("R8 count saturates", int'(count), 0);
        chk("R8 idle at zero target", int'(sweeping), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule